// File: doc/BRIEF.md
# Banked Memory Mapper

This block sits between an 8-bit processor with a 16-bit address bus and four physical targets: a boot ROM, a BASIC ROM, an 18-bit work RAM, and a 2 KB RAM that is shared with a second processor. Software sets the mapping by writing a small register file on four I/O offsets. The register file is write-only. A 2-bit mode field picks one of three memory maps, and a fourth value leaves the whole space unmapped. A 4-bit bank field moves the top 16 KB window within the work RAM or onto the shared RAM. A 3-bit sub-bank field picks a page of the BASIC ROM.

For every memory access the decode is purely combinational. It produces a one-hot target select, the translated 18-bit physical address and a write enable for each writable target. Writes to ROM, and writes or reads that land in unmapped areas, are dropped. These accesses raise a miss flag, and the data path above the block then returns 0xFF on such reads.

Top module: `bank_mapper`

## Requirements
- R1: After reset the mode, the upper bank (MA), the ROM sub-bank (MO) and both enable bits are all zero. With these values, an access to 0xC000 selects work RAM at 0xC000 and `cfg_en` reads 0.
- R2: When `io_wr` is high at a rising edge, the register addressed by `io_addr` is written, and the next cycle already decodes with the new value. At offset 1, bits [1:0] are the mode. At offset 2, bits [7:4] are MA and bits [2:0] are MO. At offset 3, bit 7 and bit 6 are the enables. Writes to offset 0 change nothing.
- R3: In mode 0:
  - A read of 0x0000–0x1FFF selects the boot ROM at (addr & 0x0FFF) | 0x1000.
  - A read of 0x2000–0x3FFF selects the BASIC ROM at addr.
  - Any access to 0x4000–0xBFFF selects work RAM at addr.
- R4: In modes 0 and 2, the 0xC000–0xFFFF window maps as follows:
  - MA=0 selects RAM at addr.
  - MA=1 selects RAM at addr & 0x3FFF.
  - MA=0xF selects the shared RAM at addr & 0x7FF.
  - In mode 0, every other MA value is unmapped.
- R5: In mode 2, MA values 2 to 0xD map the window to RAM at 0x10000 + (MA−2)·0x4000 + (addr & 0x3FFF). MA=0xE is unmapped.
- R6: In mode 1, 0xF800–0xFFFF selects the shared RAM at addr & 0x7FF. Every other address selects work RAM at addr. Both reads and writes are allowed.
- R7: In mode 2:
  - A read of 0x0000–0x1FFF selects the BASIC ROM at addr & 0x1FFF.
  - A read of 0x2000–0x3FFF selects the BASIC ROM at (addr & 0x1FFF) + 0x2000·(MO+1) for MO 0–2. Other MO values are unmapped.
  - 0x4000–0xBFFF selects RAM at addr.
- R8: A write to a ROM region, or any access with no mapping, selects none, keeps `we_ram` and `we_shared` low and raises `miss` in that cycle.
- R9: In mode 3 every access is unmapped.
- R10: `sel` is always one-hot, with bit 0 for the boot ROM, bit 1 for the BASIC ROM, bit 2 for work RAM, bit 3 for the shared RAM and bit 4 for none. With no strobe, `sel` is none, `phys_addr` is 0 and `miss` is low. `phys_addr` is 0 whenever none is selected.
- R11: `cfg_en` shows offset 3 bit 7 on its bit 1 and bit 6 on its bit 0. The enables have no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 2 | Register offset |
| io_wdata | input | 8 | Register write data |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| sel | output | 5 | One-hot target select |
| phys_addr | output | 18 | Translated physical address |
| we_ram | output | 1 | Work RAM write enable |
| we_shared | output | 1 | Shared RAM write enable |
| miss | output | 1 | Dropped or unmapped access |
| cfg_en | output | 2 | Stored bank enable bits |

## Verification
The assertions assume that the processor never raises `mem_rd` and `mem_wr` in the same cycle. The stimulus keeps to this assumption by picking exactly one of idle, read or write for each cycle. Register writes are allowed in the same cycle as a memory access. That access must still decode with the old register values, so the reference model updates its registers only after the capturing edge. Random register data covers all four modes and every MA and MO value, including the unmapped codes.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int AW = 16,
  parameter int PW = 18,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [1:0]    io_addr,
  input  logic [7:0]    io_wdata,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  output logic [4:0]    sel,
  output logic [PW-1:0] phys_addr,
  output logic          we_ram,
  output logic          we_shared,
  output logic          miss,
  output logic [1:0]    cfg_en
);
  localparam int T_BOOT = 0, T_BASIC = 1, T_RAM = 2, T_SHR = 3, T_NONE = 4;

  logic [1:0] mode;
  logic [3:0] ma;
  logic [2:0] mo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= '0; ma <= '0; mo <= '0; cfg_en <= '0;
    end else if (io_wr) begin
      case (io_addr)
        2'd1: mode <= io_wdata[1:0];
        2'd2: begin ma <= io_wdata[7:4]; mo <= io_wdata[2:0]; end
        2'd3: cfg_en <= io_wdata[7:6];
        default: ;
      endcase
    end

  wire [AW-1:0] a = mem_addr;
  wire upper = a[15:14] == 2'b11;
  int unsigned hit;
  logic [PW-1:0] pa;

  always_comb begin
    hit = T_NONE;
    pa  = '0;
    case (mode)
      2'd0, 2'd2: begin
        if (a[15:13] == 3'd0) begin
          hit = (mode == 2'd0) ? T_BOOT : T_BASIC;
          pa  = (mode == 2'd0) ? {5'd0, 1'b1, a[11:0]} : {5'd0, a[12:0]};
        end else if (a[15:13] == 3'd1) begin
          if (mode == 2'd0) begin
            hit = T_BASIC; pa = {2'd0, a};
          end else if (mo <= 3'd2) begin
            hit = T_BASIC; pa = {2'd0, mo + 3'd1, a[12:0]};
          end
        end else if (!upper) begin
          hit = T_RAM; pa = {2'd0, a};
        end else begin
          case (ma)
            4'h0: begin hit = T_RAM; pa = {2'd0, a}; end
            4'h1: begin hit = T_RAM; pa = {4'd0, a[13:0]}; end
            4'hF: begin hit = T_SHR; pa = {{(PW-SW){1'b0}}, a[SW-1:0]}; end
            4'hE: ;
            default: if (mode == 2'd2) begin hit = T_RAM; pa = {ma + 4'd2, a[13:0]}; end
          endcase
        end
      end
      2'd1: begin
        if (a[15:SW] == '1) begin hit = T_SHR; pa = {{(PW-SW){1'b0}}, a[SW-1:0]}; end
        else begin hit = T_RAM; pa = {2'd0, a}; end
      end
      default: ;
    endcase
  end

  wire acc  = mem_rd | mem_wr;
  wire drop = mem_wr && (hit == T_BOOT || hit == T_BASIC);
  wire none = !acc || hit == T_NONE || drop;

  assign miss      = acc && (hit == T_NONE || drop);
  assign sel       = none ? 5'b10000 : 5'(1 << hit);
  assign phys_addr = none ? '0 : pa;
  assign we_ram    = mem_wr && sel[T_RAM];
  assign we_shared = mem_wr && sel[T_SHR];

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n) $onehot(sel));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr) |-> (sel[4] && !miss && phys_addr == '0));
  assert_rom_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !(sel[0] || sel[1]));
  assert_miss_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (sel[4] && !we_ram && !we_shared));
  assert_mode3_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && (mem_rd || mem_wr)) |-> miss);
  assert_shared_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel[3] |-> phys_addr[PW-1:SW] == '0);
  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd1) |=> mode == $past(io_wdata[1:0]));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic clk = 0, rst_n = 0, io_wr = 0, mem_rd = 0, mem_wr = 0;
  logic [1:0] io_addr = 0;
  logic [7:0] io_wdata = 0;
  logic [15:0] mem_addr = 0;
  logic [4:0] sel;
  logic [17:0] phys_addr;
  logic we_ram, we_shared, miss;
  logic [1:0] cfg_en;

  int checks = 0, failures = 0;
  int m_mode = 0, m_ma = 0, m_mo = 0, m_en = 0;

  always #10 clk = ~clk;

  bank_mapper uut (.*);

  function automatic void model(input int a, input bit rd, input bit wr,
                                output int tgt, output int p);
    tgt = 4; p = 0;
    if (m_mode == 1) begin
      if (a >= 'hF800) begin tgt = 3; p = a % 'h800; end
      else begin tgt = 2; p = a; end
    end else if (m_mode == 0 || m_mode == 2) begin
      if (a < 'h2000) begin
        if (m_mode == 0) begin tgt = 0; p = 'h1000 + a % 'h1000; end
        else begin tgt = 1; p = a; end
      end else if (a < 'h4000) begin
        if (m_mode == 0) begin tgt = 1; p = a; end
        else if (m_mo <= 2) begin tgt = 1; p = (a - 'h2000) + 'h2000 * (m_mo + 1); end
      end else if (a < 'hC000) begin
        tgt = 2; p = a;
      end else begin
        if (m_ma == 0) begin tgt = 2; p = a; end
        else if (m_ma == 1) begin tgt = 2; p = a - 'hC000; end
        else if (m_ma == 15) begin tgt = 3; p = a % 'h800; end
        else if (m_mode == 2 && m_ma <= 13) begin tgt = 2; p = 'h10000 + (m_ma - 2) * 'h4000 + (a - 'hC000); end
      end
    end
    if (wr && tgt <= 1) tgt = 4;
    if (!(rd || wr)) tgt = 4;
    if (tgt == 4) p = 0;
  endfunction

  task automatic cyc(input bit iw, input int ia, input int id, input int a,
                     input bit rd, input bit wr, input string tag);
    int tgt, p;
    bit exp_miss;
    string t;
    @(negedge clk);
    io_wr = iw; io_addr = ia[1:0]; io_wdata = id[7:0];
    mem_addr = a[15:0]; mem_rd = rd; mem_wr = wr;
    #5;
    model(a, rd, wr, tgt, p);
    exp_miss = (rd || wr) && tgt == 4;
    t = tag;
    if (t == "") begin
      if (m_mode == 3) t = "R9";
      else if (exp_miss) t = "R8";
      else if (m_mode == 1) t = "R6";
      else if (m_mode == 2 && a >= 'hC000 && m_ma >= 2 && m_ma <= 13) t = "R5";
      else t = "R10";
    end
    checks++;
    if (sel !== 5'(1 << tgt) || phys_addr !== 18'(p) || miss !== exp_miss ||
        we_ram !== (wr && tgt == 2) || we_shared !== (wr && tgt == 3) || cfg_en !== 2'(m_en)) begin
      failures++;
      $display("FAIL %s: addr=%h rd=%0b wr=%0b sel=%b pa=%h miss=%0b we=%0b%0b en=%0d expected sel=%b pa=%h miss=%0b we=%0b%0b en=%0d",
        t, a, rd, wr, sel, phys_addr, miss, we_ram, we_shared, cfg_en,
        5'(1 << tgt), 18'(p), exp_miss, wr && tgt == 2, wr && tgt == 3, m_en);
    end
    @(posedge clk); #1;
    if (iw && rst_n) begin
      if (ia == 1) m_mode = id & 3;
      if (ia == 2) begin m_ma = (id >> 4) & 15; m_mo = id & 7; end
      if (ia == 3) m_en = (id >> 6) & 3;
    end
  endtask

  task automatic rd_(input int a, input string tag); cyc(0, 0, 0, a, 1, 0, tag); endtask
  task automatic wr_(input int a, input string tag); cyc(0, 0, 0, a, 0, 1, tag); endtask
  task automatic reg_(input int ia, input int d, input string tag); cyc(1, ia, d, 0, 0, 0, tag); endtask

  initial begin
    repeat (3) @(posedge clk);
    rd_('hC123, "R1");
    #1 rst_n = 1;
    rd_('hC123, "R1");
    rd_('h0ABC, "R3"); rd_('h1FFF, "R3"); rd_('h2345, "R3"); wr_('h5000, "R3"); rd_('hBFFF, "R3");
    wr_('h0100, "R8"); wr_('h3000, "R8");
    cyc(0, 0, 0, 'h4000, 0, 0, "R10");
    reg_(2, 'h10, "R2"); rd_('hC010, "R4");
    reg_(2, 'hF0, "R2"); wr_('hC7FF, "R4"); rd_('hFFFF, "R4");
    reg_(2, 'h20, "R2"); rd_('hC000, "R4");
    reg_(0, 'hFF, "R2"); rd_('hC000, "R2");
    reg_(3, 'hC0, "R11"); rd_('h1000, "R11");
    reg_(1, 1, "R2"); wr_('h0000, "R6"); rd_('hF7FF, "R6"); wr_('hF800, "R6"); rd_('hFFFF, "R6");
    reg_(1, 2, "R2"); rd_('h0123, "R7"); wr_('h0123, "R8");
    for (int m = 0; m < 8; m++) begin
      reg_(2, m, "R2"); rd_('h2ABC, "R7");
    end
    for (int b = 0; b < 16; b++) begin
      reg_(2, b << 4, "R2"); wr_('hC000 + b, "R5"); rd_('hFFFF, "R5");
    end
    reg_(1, 3, "R2"); rd_('h4000, "R9"); wr_('hF900, "R9");
    cyc(1, 1, 0, 'hC000, 1, 0, "R2"); rd_('h0010, "R2");
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 3;
      cyc(($urandom % 4) == 0, $urandom % 4, $urandom % 256, $urandom % 65536, op == 1, op == 2, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule